// File: doc/BRIEF.md
# Prioritized Latched Interrupt Controller

This block gathers four interrupt sources into four sticky request flags and decides, at the moment the processor finishes a pack, whether to divert into a handler and which fixed entry address to use. Source 4 comes from an asynchronous external pin that is synchronized and edge-detected in the block. Source 1 comes from a timer wrap pulse and source 3 from a receive-complete pulse. Source 2 is a software trap that is raised only through the control register. Each hardware source has its own enable, supplied from outside.

A single global enable gates diversion. Diversion clears the global enable, so handlers do not nest. The enable comes back when the processor reports a return jump through the link register. Software can also write the enable, but only when the write carries a separate "valid" bit, so a write that only clears flags leaves the enable untouched. Flags are never cleared by diversion itself. Software clears flags 1, 2 and 4 through the control register. Flag 3 is cleared when the receive data register is read.

Top module: `prio_irq_unit`

## Requirements
- R1: After reset all four flags are 0, the global enable is 0, `take_irq` is 0 and `vec_addr` is 0.
- R2: A timer wrap pulse sets flag 1 and a receive-done pulse sets flag 3, each only while its enable is 1. A rising edge on `ext_pin` sets flag 4 only while `en_ext` is 1, at the third rising clock edge after the pin rises, never earlier.
- R3: Holding `ext_pin` high sets flag 4 once only. After flag 4 is cleared, a pin that stays high does not set it again.
- R4: Flags hold until cleared. A write with `reg_wdata` bit 0 clears flag 1, bit 1 clears flag 2 and bit 2 clears flag 4. A `rx_data_read` pulse clears flag 3.
- R5: A write with bit 3 set raises flag 2, whatever the enables.
- R6: When a flag is set and cleared in the same cycle, it ends up set.
- R7: `take_irq` is 1 exactly in a cycle with `pack_end` 1, the global enable 1 and at least one flag set.
- R8: The highest-numbered set flag selects `vec_addr`: flag 4 gives 0x10, flag 3 gives 0x40, flag 2 gives 0x30 and flag 1 gives 0x20. With no flag set, `vec_addr` is 0.
- R9: After a cycle with `take_irq` 1, the global enable is 0 and the flags are unchanged.
- R10: A `ret_jump` pulse sets the global enable.
- R11: A write loads the global enable from bit 4 only when bit 5 of the same write is 1. Otherwise the enable keeps its value. `reg_rdata` gives the flags in bits 3:0 (flag 1 in bit 0) and the global enable in bit 4.
- R12: When diversion coincides with a return or with an enable write, the global enable ends up 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ext_pin | input | 1 | Asynchronous external request pin |
| tmr_wrap | input | 1 | Timer wrap pulse |
| rx_done | input | 1 | Receive-complete pulse |
| rx_data_read | input | 1 | Receive data register read pulse, clears flag 3 |
| en_tmr | input | 1 | Enable for flag 1 |
| en_rx | input | 1 | Enable for flag 3 |
| en_ext | input | 1 | Enable for flag 4 |
| pack_end | input | 1 | Current pack finishes this cycle |
| ret_jump | input | 1 | Return jump through the link register executes |
| reg_wr | input | 1 | Control register write strobe |
| reg_wdata | input | 6 | Write data: clear and set bits, enable value, enable valid |
| reg_rdata | output | 5 | Flags in bits 3:0, global enable in bit 4 |
| take_irq | output | 1 | Divert to a handler at this pack end |
| vec_addr | output | 32 | Handler entry byte address |
| gie | output | 1 | Global enable |

## Verification
The hardest situation to reach from the ports is a diversion that lands in the same cycle as a return jump and a qualified enable write, because all three drive the enable at once. The stimulus first builds pending flags with the enable on. It then raises `pack_end`, `ret_jump` and a write with the valid bit in one cycle and checks that the enable reads 0 afterwards. Set-against-clear races are produced the same way: a clear write is lined up with a source pulse or a trap bit in the same cycle.

// File: rtl/irq_pkg.sv
package irq_pkg;
    localparam int NSRC = 4;

    // control write bit positions
    localparam int WB_CLR1  = 0;
    localparam int WB_CLR2  = 1;
    localparam int WB_CLR4  = 2;
    localparam int WB_TRAP  = 3;
    localparam int WB_GVAL  = 4;
    localparam int WB_GVLD  = 5;
    localparam int WD_W     = 6;
    localparam int RD_W     = 5;

    // flag index (0-based) of each source
    localparam int IX_TMR   = 0;
    localparam int IX_TRAP  = 1;
    localparam int IX_RX    = 2;
    localparam int IX_EXT   = 3;

    // entry offset for a flag index; order is not monotonic
    function automatic logic [7:0] entry_of(input int idx);
        case (idx)
            0:       entry_of = 8'h20;
            1:       entry_of = 8'h30;
            2:       entry_of = 8'h40;
            3:       entry_of = 8'h10;
            default: entry_of = 8'h00;
        endcase
    endfunction

    typedef struct packed {
        logic gie;
    } ctl_state_t;
endpackage

// File: rtl/irq_edge_sync.sv
module irq_edge_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic din,
    output logic rise
);
    localparam int SW = STAGES + 1;

    logic [SW-1:0] sh_d, sh_q;

    always_comb begin
        sh_d = {sh_q[SW-2:0], din};
    end

    always_ff @(posedge clk) begin
        if (!rst_n) sh_q <= '0;
        else        sh_q <= sh_d;
    end

    assign rise = sh_q[STAGES-1] & ~sh_q[STAGES];

    // a detected rise lasts one cycle only (R3)
    p_single_rise_r3: assert property (@(posedge clk) disable iff (!rst_n)
        rise |=> !rise);
endmodule

// File: rtl/irq_flag_bank.sv
module irq_flag_bank #(
    parameter int N = 4
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] set_i,
    input  logic [N-1:0] clr_i,
    output logic [N-1:0] pend
);
    logic [N-1:0] pend_d, pend_q;

    always_comb begin
        for (int i = 0; i < N; i++) begin
            pend_d[i] = (pend_q[i] & ~clr_i[i]) | set_i[i];
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) pend_q <= '0;
        else        pend_q <= pend_d;
    end

    assign pend = pend_q;

    for (genvar g = 0; g < N; g++) begin : g_chk
        // flags persist until cleared (R4)
        p_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
            (pend_q[g] && !clr_i[g]) |=> pend_q[g]);
        // set wins over clear (R6)
        p_set_wins_r6: assert property (@(posedge clk) disable iff (!rst_n)
            set_i[g] |=> pend_q[g]);
    end
endmodule

// File: rtl/irq_select.sv
module irq_select
    import irq_pkg::*;
#(
    parameter int VEC_W = 32
) (
    input  logic [NSRC-1:0]  pend,
    input  logic             gie,
    input  logic             pack_end,
    output logic             take,
    output logic [VEC_W-1:0] vec
);
    logic       any;
    logic [7:0] off;

    always_comb begin
        any = 1'b0;
        off = 8'h00;
        for (int i = 0; i < NSRC; i++) begin
            if (pend[i]) begin
                any = 1'b1;
                off = entry_of(i);
            end
        end
        vec  = VEC_W'(off);
        take = any & gie & pack_end;
    end
endmodule

// File: rtl/prio_irq_unit.sv
module prio_irq_unit
    import irq_pkg::*;
#(
    parameter int VEC_W     = 32,
    parameter int SYNC_STGS = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ext_pin,
    input  logic             tmr_wrap,
    input  logic             rx_done,
    input  logic             rx_data_read,
    input  logic             en_tmr,
    input  logic             en_rx,
    input  logic             en_ext,
    input  logic             pack_end,
    input  logic             ret_jump,
    input  logic             reg_wr,
    input  logic [WD_W-1:0]  reg_wdata,
    output logic [RD_W-1:0]  reg_rdata,
    output logic             take_irq,
    output logic [VEC_W-1:0] vec_addr,
    output logic             gie
);
    ctl_state_t st_d, st_q;
    logic            ext_rise;
    logic [NSRC-1:0] set_v, clr_v, pend;

    irq_edge_sync #(.STAGES(SYNC_STGS)) u_sync (
        .clk  (clk),
        .rst_n(rst_n),
        .din  (ext_pin),
        .rise (ext_rise)
    );

    always_comb begin
        set_v          = '0;
        clr_v          = '0;
        set_v[IX_TMR]  = tmr_wrap & en_tmr;
        set_v[IX_RX]   = rx_done  & en_rx;
        set_v[IX_EXT]  = ext_rise & en_ext;
        set_v[IX_TRAP] = reg_wr & reg_wdata[WB_TRAP];
        clr_v[IX_TMR]  = reg_wr & reg_wdata[WB_CLR1];
        clr_v[IX_TRAP] = reg_wr & reg_wdata[WB_CLR2];
        clr_v[IX_EXT]  = reg_wr & reg_wdata[WB_CLR4];
        clr_v[IX_RX]   = rx_data_read;
    end

    irq_flag_bank #(.N(NSRC)) u_flags (
        .clk  (clk),
        .rst_n(rst_n),
        .set_i(set_v),
        .clr_i(clr_v),
        .pend (pend)
    );

    irq_select #(.VEC_W(VEC_W)) u_sel (
        .pend    (pend),
        .gie     (st_q.gie),
        .pack_end(pack_end),
        .take    (take_irq),
        .vec     (vec_addr)
    );

    always_comb begin
        st_d = st_q;
        if (reg_wr && reg_wdata[WB_GVLD]) st_d.gie = reg_wdata[WB_GVAL];
        if (ret_jump)                     st_d.gie = 1'b1;
        if (take_irq)                     st_d.gie = 1'b0;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign gie       = st_q.gie;
    assign reg_rdata = {st_q.gie, pend};

    // entry disables further diversion (R9, R12)
    p_entry_clears_r9: assert property (@(posedge clk) disable iff (!rst_n)
        take_irq |=> !gie);
    // diversion leaves flags alone (R9)
    p_flags_kept_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (take_irq && !reg_wr && !rx_data_read && !tmr_wrap && !rx_done && !ext_rise)
        |=> $stable(pend));
    // unqualified writes do not move the enable (R11)
    p_gie_needs_vld_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr && !reg_wdata[WB_GVLD] && !ret_jump && !take_irq) |=> $stable(gie));
    // return reenables (R10)
    p_return_sets_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (ret_jump && !take_irq) |=> gie);
    // diversion only with enable, boundary and a pending flag (R7)
    p_take_cond_r7: assert property (@(posedge clk) disable iff (!rst_n)
        take_irq |-> (gie && pack_end && pend != '0));
    // highest source wins (R8)
    p_top_prio_r8: assert property (@(posedge clk) disable iff (!rst_n)
        pend[IX_EXT] |-> (vec_addr == VEC_W'(8'h10)));
endmodule

// File: tb/sim_prio_irq_unit.sv
module sim_prio_irq_unit;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       ext_pin = 0, tmr_wrap = 0, rx_done = 0, rx_data_read = 0;
    logic       en_tmr = 0, en_rx = 0, en_ext = 0;
    logic       pack_end = 0, ret_jump = 0, reg_wr = 0;
    logic [5:0] reg_wdata = '0;
    logic [4:0] reg_rdata;
    logic       take_irq, gie;
    logic [31:0] vec_addr;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 0;

    always #2 clk = ~clk;

    prio_irq_unit u0 (
        .clk(clk), .rst_n(rst_n), .ext_pin(ext_pin), .tmr_wrap(tmr_wrap),
        .rx_done(rx_done), .rx_data_read(rx_data_read), .en_tmr(en_tmr),
        .en_rx(en_rx), .en_ext(en_ext), .pack_end(pack_end), .ret_jump(ret_jump),
        .reg_wr(reg_wr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .take_irq(take_irq), .vec_addr(vec_addr), .gie(gie)
    );

    task automatic cyc(input int n = 1);
        for (int i = 0; i < n; i++) begin
            @(posedge clk);
            #1;
        end
    endtask

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [5:0] d);
        reg_wr = 1; reg_wdata = d;
        cyc();
        reg_wr = 0; reg_wdata = '0;
    endtask

    task automatic t_reset;
        check("R1 rdata", 32'(reg_rdata), 0);
        check("R1 take", 32'(take_irq), 0);
        check("R1 vec", vec_addr, 0);
    endtask

    task automatic t_sources;
        tmr_wrap = 1; rx_done = 1; ext_pin = 1;
        cyc();
        tmr_wrap = 0; rx_done = 0;
        cyc(4);
        check("R2 disabled sources", 32'(reg_rdata[3:0]), 0);
        ext_pin = 0;
        cyc(4);
        en_tmr = 1; en_rx = 1; en_ext = 1;
        tmr_wrap = 1; cyc(); tmr_wrap = 0;
        check("R2 timer flag", 32'(reg_rdata[3:0]), 32'h1);
        rx_done = 1; cyc(); rx_done = 0;
        check("R2 rx flag", 32'(reg_rdata[3:0]), 32'h5);
        ext_pin = 1;
        cyc(2);
        check("R2 ext not yet", 32'(reg_rdata[3:0]), 32'h5);
        cyc();
        check("R2 ext latency", 32'(reg_rdata[3:0]), 32'hD);
    endtask

    task automatic t_level_and_clear;
        cyc(3);
        wr(6'b000100);
        check("R4 clear ext", 32'(reg_rdata[3:0]), 32'h5);
        cyc(4);
        check("R3 held pin no reset", 32'(reg_rdata[3:0]), 32'h5);
        ext_pin = 0;
        wr(6'b000000);
        check("R4 null write keeps", 32'(reg_rdata[3:0]), 32'h5);
        wr(6'b000001);
        check("R4 clear timer", 32'(reg_rdata[3:0]), 32'h4);
        rx_data_read = 1; cyc(); rx_data_read = 0;
        check("R4 rx read clears", 32'(reg_rdata[3:0]), 32'h0);
    endtask

    task automatic t_trap;
        wr(6'b001000);
        check("R5 trap", 32'(reg_rdata[3:0]), 32'h2);
        wr(6'b001010);
        check("R6 trap vs clear", 32'(reg_rdata[3:0]), 32'h2);
        tmr_wrap = 1;
        wr(6'b000001);
        tmr_wrap = 0;
        check("R6 wrap vs clear", 32'(reg_rdata[3:0]), 32'h3);
    endtask

    task automatic t_enable_write;
        wr(6'b010000);
        check("R11 no valid", 32'(gie), 0);
        wr(6'b110000);
        check("R11 valid set", 32'(reg_rdata[4]), 1);
        wr(6'b100000);
        check("R11 valid clear", 32'(gie), 0);
        wr(6'b110000);
    endtask

    task automatic t_take;
        check("R7 no boundary", 32'(take_irq), 0);
        check("R8 vec trap", vec_addr, 32'h30);
        pack_end = 1; #1;
        check("R7 take", 32'(take_irq), 1);
        cyc();
        pack_end = 0;
        check("R9 gie cleared", 32'(gie), 0);
        check("R9 flags kept", 32'(reg_rdata[3:0]), 32'h3);
        pack_end = 1; #1;
        check("R7 masked", 32'(take_irq), 0);
        pack_end = 0;
        ret_jump = 1; cyc(); ret_jump = 0;
        check("R10 return", 32'(gie), 1);
        rx_done = 1; cyc(); rx_done = 0;
        check("R8 vec rx", vec_addr, 32'h40);
        ext_pin = 1; cyc(3);
        check("R8 vec ext", vec_addr, 32'h10);
        ext_pin = 0;
        wr(6'b000110);
        rx_data_read = 1; cyc(); rx_data_read = 0;
        check("R8 vec timer", vec_addr, 32'h20);
        wr(6'b000001);
        check("R8 vec none", vec_addr, 0);
        pack_end = 1; #1;
        check("R7 nothing pending", 32'(take_irq), 0);
        pack_end = 0;
    endtask

    task automatic t_collide;
        wr(6'b001000);
        pack_end = 1; ret_jump = 1; reg_wr = 1; reg_wdata = 6'b110000;
        cyc();
        pack_end = 0; ret_jump = 0; reg_wr = 0; reg_wdata = '0;
        check("R12 entry wins", 32'(gie), 0);
    endtask

    initial begin
        cyc(3);
        rst_n = 1;
        #1;
        t_reset();
        t_sources();
        t_level_and_clear();
        t_trap();
        t_enable_write();
        t_take();
        t_collide();
        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        #(4 * 200000);
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: actual hung expected done");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end
endmodule